// File: doc/BRIEF.md
# Paged 32-bit register read-modify-write over Clause 22 MDIO

This block lets a host reach a 32-bit register space that sits behind a Clause 22 management bus, where each single access moves only 16 bits. One request carries a 32-bit register address, a clear mask and a set mask. The block breaks this request into a fixed series of Clause 22 transactions and hands them one at a time to a downstream frame engine. The series is: a page-select write, a read of the low half, a read of the high half, a write of the low half and a write of the high half. The value written back is the old value with the clear bits removed and the set bits added.

The address is split into fields. Bits [31:24] are a switch address. Its top three bits pick the page-select PHY address, and its low five bits give the page-select register number. Bits [23:8] are the 16-bit page. Bits [7:5] pick the data PHY address. Bits [4:2] give the data register offset. A read-only request stops after the two reads and returns the assembled 32-bit value. Any transaction that reports an error ends the series at once. The block does not drive the serial wire itself.

Top module: `mdio_wide_rmw`

## Requirements
- R1: The first transaction of every request is a write. Its PHY address is 0x18 OR addr[31:29], so its bits [4:3] are 2'b11. Its register number is addr[28:24]. Its data is addr[23:8].
- R2: The second transaction is a read. Its PHY address is 0x10 OR addr[7:5], so its bits [4:3] are 2'b10. Its register number is addr AND 0x1C, which is {addr[4:2], 2'b00}.
- R3: The third transaction is a read from the same PHY address. Its register number is the R2 register number with bit 1 set. The old value is formed as {high read data, low read data}.
- R4: A read-modify-write request then writes the low 16 bits of (old AND NOT clear) OR set to the R2 register. It then writes the high 16 bits to the R3 register. The low half always goes first.
- R5: Each transaction holds mdio_req high, with PHY address, register number, write flag and write data stable, until the cycle in which mdio_ack is high. The next transaction starts no earlier than the following cycle.
- R6: If a transaction completes with mdio_err high, no further transaction is issued for that request. done rises in the next cycle with done_err high. done_err is never high without done.
- R7: done is a single-cycle pulse in the cycle after the final acknowledge. busy is high from the cycle after a request is accepted until done rises, and busy is low in the done cycle.
- R8: req_valid is ignored while busy is high. A stray request during a series changes neither the transaction sequence nor the result.
- R9: A request with req_read_only high issues only the three transactions of R1 to R3. It then pulses done, and rd_data equals {high half, low half}.
- R10: While rst_n is low, and after it is released, busy, done, done_err and mdio_req are low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a request; accepted when not busy |
| req_read_only | input | 1 | 1: read only, 0: read-modify-write |
| req_addr | input | 32 | 32-bit register address |
| req_clear | input | 32 | Bits to clear in the old value |
| req_set | input | 32 | Bits to set after clearing |
| busy | output | 1 | A series is in progress |
| done | output | 1 | One-cycle end-of-series pulse |
| done_err | output | 1 | Error flag, valid with done |
| rd_data | output | 32 | Old 32-bit value read during the series |
| mdio_req | output | 1 | Transaction request to frame engine |
| mdio_phy | output | 5 | PHY address of the transaction |
| mdio_reg | output | 5 | Register number of the transaction |
| mdio_wr | output | 1 | 1: write, 0: read |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Transaction complete (one cycle) |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| mdio_err | input | 1 | Transaction error, valid with mdio_ack |

## Verification
The assertions take three things for granted about the frame engine:
- mdio_ack is a single-cycle pulse given only while mdio_req is high.
- mdio_err and mdio_rdata matter only in that cycle.
- The engine never acknowledges a transaction that was not requested.

The bench responder keeps to this. It raises mdio_ack only after seeing mdio_req, waits a configurable number of cycles first, and drops it on the next clock. It injects an error on a chosen transaction index. Requests from the host side may arrive at any time, so the bench also sends requests while busy to exercise R8.

// File: rtl/mdio_wide_rmw.sv
module mdio_wide_rmw #(
  parameter logic [4:0] PAGE_PHY_BASE = 5'h18,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read_only,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_clear,
  input  logic [31:0] req_set,
  output logic        busy,
  output logic        done,
  output logic        done_err,
  output logic [31:0] rd_data,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic        mdio_wr,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_ack,
  input  logic [15:0] mdio_rdata,
  input  logic        mdio_err
);

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_RDLO, S_RDHI, S_WRLO, S_WRHI} st_t;

  st_t         st;
  logic [31:0] addr_q, clr_q, set_q;
  logic        ro_q;
  logic [15:0] lo_q, hi_q;

  wire [31:0] merged = ({hi_q, lo_q} & ~clr_q) | set_q;
  wire        step   = mdio_req & mdio_ack;
  wire        hi_sel = (st == S_RDHI) || (st == S_WRHI);

  assign busy     = (st != S_IDLE);
  assign mdio_req = busy;
  assign rd_data  = {hi_q, lo_q};
  assign mdio_wr  = (st == S_PAGE) || (st == S_WRLO) || (st == S_WRHI);
  assign mdio_phy = (st == S_PAGE) ? (PAGE_PHY_BASE | {2'b00, addr_q[31:29]})
                                   : (DATA_PHY_BASE | {2'b00, addr_q[7:5]});
  assign mdio_reg = (st == S_PAGE) ? addr_q[28:24] : {addr_q[4:2], hi_sel, 1'b0};

  always_comb begin
    case (st)
      S_PAGE:  mdio_wdata = addr_q[23:8];
      S_WRLO:  mdio_wdata = merged[15:0];
      S_WRHI:  mdio_wdata = merged[31:16];
      default: mdio_wdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      done_err <= 1'b0;
      addr_q   <= '0;
      clr_q    <= '0;
      set_q    <= '0;
      ro_q     <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          addr_q <= req_addr;
          clr_q  <= req_clear;
          set_q  <= req_set;
          ro_q   <= req_read_only;
          st     <= S_PAGE;
        end
      end else if (step) begin
        if (mdio_err) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          done_err <= 1'b1;
        end else begin
          case (st)
            S_PAGE: st <= S_RDLO;
            S_RDLO: begin
              lo_q <= mdio_rdata;
              st   <= S_RDHI;
            end
            S_RDHI: begin
              hi_q <= mdio_rdata;
              if (ro_q) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st <= S_WRLO;
              end
            end
            S_WRLO: st <= S_WRHI;
            default: begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                              && $stable(mdio_wr) && $stable(mdio_wdata));

  p_page_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_req) |-> mdio_wr && (mdio_phy[4:3] == 2'b11));

  p_abort_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && mdio_ack && mdio_err |=> done && done_err && !mdio_req);

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ro_no_data_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && mdio_wr && (mdio_phy[4:3] == 2'b10) |-> !ro_q);

endmodule

// File: tb/mdio_wide_rmw_tb.sv
`timescale 1ns/1ps
module mdio_wide_rmw_tb;

  typedef struct packed {
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic        wr;
    logic [15:0] d;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_read_only = 1'b0;
  logic [31:0] req_addr = '0, req_clear = '0, req_set = '0;
  logic busy, done, done_err;
  logic [31:0] rd_data;
  logic mdio_req, mdio_wr;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata;
  logic mdio_ack = 1'b0, mdio_err = 1'b0;
  logic [15:0] mdio_rdata = '0;

  always #2.5 clk = ~clk;

  mdio_wide_rmw u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read_only(req_read_only),
    .req_addr(req_addr), .req_clear(req_clear), .req_set(req_set),
    .busy(busy), .done(done), .done_err(done_err), .rd_data(rd_data),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wr(mdio_wr),
    .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .mdio_err(mdio_err)
  );

  int checks = 0, fails = 0;
  logic [15:0] regs [0:1023];
  txn_t q[$];
  int lat = 0, err_at = -1, tidx = 0, cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Responder and per-clock comparison against the expected transaction queue
  always @(negedge clk) begin
    if (!rst_n) begin
      mdio_ack = 1'b0; cnt = 0;
    end else if (mdio_ack) begin
      mdio_ack = 1'b0; mdio_err = 1'b0; cnt = 0;
    end else if (mdio_req) begin
      if (q.size() == 0) begin
        if (cnt == 0) chk(1'b0, "R6 R8 extra transaction", {mdio_phy, mdio_reg}, 0);
        cnt = 1;
      end else begin
        if (cnt == 0) begin
          chk(mdio_phy == q[0].phy, $sformatf("R1 R2 R3 R4 phy of txn %0d", tidx), mdio_phy, q[0].phy);
          chk(mdio_reg == q[0].rg,  $sformatf("R1 R2 R3 R4 reg of txn %0d", tidx), mdio_reg, q[0].rg);
          chk(mdio_wr == q[0].wr,   $sformatf("R4 R9 write flag of txn %0d", tidx), mdio_wr, q[0].wr);
          if (q[0].wr) chk(mdio_wdata == q[0].d, $sformatf("R1 R4 wdata of txn %0d", tidx), mdio_wdata, q[0].d);
        end
        if (cnt >= lat) begin
          mdio_ack = 1'b1;
          mdio_err = (tidx == err_at);
          if (mdio_wr && !mdio_err) regs[{mdio_phy, mdio_reg}] = mdio_wdata;
          mdio_rdata = regs[{mdio_phy, mdio_reg}];
          if (mdio_err) q.delete(); else void'(q.pop_front());
          tidx++;
        end else cnt++;
      end
    end
  end

  task automatic do_op(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                       input bit ro, input int l, input int e, input bit stray);
    logic [7:0] sw;
    logic [4:0] pp, dp, rl, rh;
    logic [31:0] oldv, newv;
    int n;
    bit seen;
    sw = a[31:24];
    pp = 5'(8'h18 | (sw >> 5));
    dp = 5'(8'h10 | ((a >> 5) & 8'h7));
    rl = 5'(a & 32'h1C);
    rh = rl | 5'h2;
    oldv = {regs[{dp, rh}], regs[{dp, rl}]};
    newv = (oldv & ~c) | s;
    q.delete();
    q.push_back('{pp, 5'(sw & 8'h1F), 1'b1, a[23:8]});
    q.push_back('{dp, rl, 1'b0, 16'h0});
    q.push_back('{dp, rh, 1'b0, 16'h0});
    if (!ro) begin
      q.push_back('{dp, rl, 1'b1, newv[15:0]});
      q.push_back('{dp, rh, 1'b1, newv[31:16]});
    end
    lat = l; err_at = e; tidx = 0;
    req_addr = a; req_clear = c; req_set = s; req_read_only = ro; req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    req_valid = 1'b0;
    seen = 0;
    for (n = 0; n < 300 && !seen; n++) begin
      if (stray && n == 2) begin
        req_valid = 1'b1; req_addr = ~a; req_read_only = ~ro; req_set = 32'hFFFF_FFFF;
      end
      if (stray && n == 5) req_valid = 1'b0;
      if (done) seen = 1; else @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, "R7 done reached", seen, 1);
    chk(done_err == (e >= 0), "R6 done_err", done_err, e >= 0);
    chk(busy == 1'b0, "R7 busy low with done", busy, 0);
    chk(q.size() == 0, "R4 R6 R9 all expected transactions issued", q.size(), 0);
    if (ro && e < 0) chk(rd_data == oldv, "R9 rd_data", rd_data, oldv);
    if (!ro && e < 0) chk({regs[{dp, rh}], regs[{dp, rl}]} == newv, "R4 stored value", {regs[{dp, rh}], regs[{dp, rl}]}, newv);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single pulse", done, 0);
    chk(mdio_req == 1'b0, "R8 no request accepted after series", mdio_req, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) regs[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && done_err == 0 && mdio_req == 0, "R10 reset state",
        {busy, done, done_err, mdio_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mdio_req == 0, "R10 idle after reset", {busy, mdio_req}, 0);
    do_op(32'hA512_346C, 32'hFFFF_0000, 32'h0000_0F0F, 0, 0, -1, 0);
    do_op(32'hA512_346C, 32'h0, 32'h0, 1, 3, -1, 0);
    do_op(32'h0000_0000, 32'h0, 32'h0, 1, 1, -1, 0);
    do_op(32'hFFFF_FFFF, 32'h0, 32'h0, 0, 1, -1, 0);
    do_op(32'h3C00_8114, 32'h00FF_00FF, 32'h8000_0001, 0, 2, -1, 1);
    do_op(32'h1234_5678, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0);
    do_op(32'h1234_5678, 32'hFFFF_FFFF, 32'h1, 0, 1, 2, 0);
    do_op(32'h1234_5678, 32'hFFFF_FFFF, 32'h1, 0, 0, 4, 0);
    do_op(32'h1234_5678, 32'h0, 32'h0, 1, 2, 1, 0);
    do_op(32'h1234_5678, 32'h0, 32'h0, 1, 0, -1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule